// File: doc/BRIEF.md
# Sixteen-Pin Configurable GPIO Port

This block is a general-purpose I/O port of sixteen pins, controlled through a small register bus. Software sets each pin's direction and output level. It can switch any output pin to open-drain operation. It can also mark any pin as analog, which hides that pin's digital level from the readable port value. Each pin has a separate output-enable and output-value signal that go to a tri-state pad. The pad level comes back on a per-pin input that feeds a sampling register.

A read returns data on the cycle in which it is requested. The readable port value is taken from a one-stage sampling register. A change on the pads, whether caused by a latch write, a direction change or an outside source, reaches that value exactly one clock later. Software must therefore leave one idle cycle between changing a pin and reading it back. Writes to the port address and to the latch address both land in the output latch. Reading the latch returns the stored contents. Reading the port returns the sampled pad levels.

Top module: `gpio_port16`

## Requirements
- R1: After reset every pin is an input (pad_oe all 0). Reads then return FFFF from address 0 (direction) and from address 4 (analog select), 0000 from address 2 (latch) and from address 3 (open-drain), and 0000 from address 1 (port).
- R2: A write to address 0 sets the direction word and is read back from the same address. A bit of 1 makes that pin an input with pad_oe low. A bit of 0 makes it an output.
- R3: An output pin whose open-drain bit is 0 has pad_oe high and drives pad_out equal to its latch bit.
- R4: An output pin whose open-drain bit (address 3) is 1 drives low (pad_oe 1, pad_out 0) when its latch bit is 0. When its latch bit is 1 it releases the pad (pad_oe 0).
- R5: A write to address 1 or to address 2 updates the output latch. A read of address 2 returns the latch contents, not the pad levels.
- R6: A read of address 1 returns the sampled pad level of each pin whose analog bit (address 4) is 0. Every pin whose analog bit is 1 reads as 0.
- R7: An analog-selected pin whose direction bit is 0 still drives its latch value onto its pad.
- R8: A change on a pad appears in the address-1 read one clock after the edge that caused it. A read in the first cycle after a write or direction change returns the old value. A read in the cycle after that returns the new value.
- R9: A write to addresses 5 to 7 changes no register, and reads of those addresses return 0.
- R10: bus_rdata is 0 whenever bus_sel is low or bus_wr is high.
- R11: A released open-drain pin reads back the level of the external pull (high), or low when an outside source pulls the line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read |
| pad_in | input | 16 | Level seen at each pad |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin driven value |

## Verification
If a configuration register holds a wrong value, pad_oe or pad_out shows it in the same cycle, because the pad controls are combinational from the stored bits. A register read shows it on the next access. A fault in the sampling stage or in the analog mask shows up only on an address-1 read. That read lags the pads by exactly one cycle, so the bench reads the port both one cycle and two cycles after each change. One idle cycle too many or too few in the input path then gives a miscompare.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the GPIO port: register word addresses and
// a helper that tells mapped addresses from unmapped ones.
// Assumes a 3-bit word address on the register bus.
package gpio_port_pkg;

    localparam int ADDR_W = 3;

    // Word addresses of the port registers.
    typedef enum logic [ADDR_W-1:0] {
        RA_DIR   = 3'd0,   // direction, 1 = input
        RA_PORT  = 3'd1,   // sampled pads on read, latch on write
        RA_LAT   = 3'd2,   // output latch
        RA_ODRN  = 3'd3,   // open-drain enable
        RA_ANSEL = 3'd4    // analog select, 1 = pin reads as 0
    } reg_addr_e;

    localparam logic [ADDR_W-1:0] LAST_MAPPED = 3'd4;

    // Returns 1 when the address selects an existing register.
    function automatic logic addr_is_mapped(input logic [ADDR_W-1:0] a);
        return (a <= LAST_MAPPED);
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
// Configuration register file of the GPIO port.
// Holds the direction, latch, open-drain and analog-select words.
// Assumes one write per cycle; a write to an unmapped address is dropped.
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      lat_q,
    output logic [W-1:0]      od_q,
    output logic [W-1:0]      ana_q
);

    // Reset values: all inputs, latch clear, push-pull, all analog.
    localparam logic [W-1:0] DIR_RST = '1;
    localparam logic [W-1:0] LAT_RST = '0;
    localparam logic [W-1:0] OD_RST  = '0;
    localparam logic [W-1:0] ANA_RST = '1;

    logic sel_dir, sel_lat, sel_od, sel_ana;

    // Decode which register a write targets.
    always_comb begin
        sel_dir = 1'b0;
        sel_lat = 1'b0;
        sel_od  = 1'b0;
        sel_ana = 1'b0;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_DIR:          sel_dir = 1'b1;
                RA_PORT, RA_LAT: sel_lat = 1'b1;
                RA_ODRN:         sel_od  = 1'b1;
                RA_ANSEL:        sel_ana = 1'b1;
                default:         ;
            endcase
        end
    end

    // Direction register.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= DIR_RST;
        else if (sel_dir) dir_q <= wdata;
    end

    // Output latch, written from either the port or latch address.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_q <= LAT_RST;
        else if (sel_lat) lat_q <= wdata;
    end

    // Open-drain enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      od_q <= OD_RST;
        else if (sel_od) od_q <= wdata;
    end

    // Analog select register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ana_q <= ANA_RST;
        else if (sel_ana) ana_q <= wdata;
    end

endmodule

// File: rtl/gpio_pad_drv.sv
// Per-pin pad drive logic of the GPIO port.
// An output pin drives its latch bit in push-pull mode. In open-drain mode
// it only pulls low and releases the line for a latch bit of 1.
// Assumes the analog select has no effect on the drive path.
module gpio_pad_drv #(
    parameter int W = 16
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] lat,
    input  logic [W-1:0] od,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic is_out;
        logic od_release;

        // Pin drives only when its direction bit selects output.
        assign is_out = ~dir[i];

        // An open-drain pin with a high latch bit lets the line float.
        assign od_release = od[i] & lat[i];

        // Enable and value seen by the pad.
        always_comb begin
            pad_oe[i]  = is_out & ~od_release;
            pad_out[i] = lat[i] & ~od[i];
        end
    end

endmodule

// File: rtl/gpio_in_sample.sv
// Input sampling chain of the GPIO port.
// STAGES registers in series capture the pad levels. The read-back value
// lags the pads by STAGES clocks (one with the default).
// Assumes the pads are sampled on every clock with no enable.
module gpio_in_sample #(
    parameter int W      = 16,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] smp_q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw pad levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= pad_in;
            end
        end else begin : g_next
            // Later stages pass the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign smp_q = stg[STAGES-1];

endmodule

// File: rtl/gpio_port16.sv
// Top of the sixteen-pin GPIO port.
// It joins the register file, the pad drive and the input sampling chain,
// and it returns read data in the same cycle through a multiplexer.
// Assumes a single-cycle bus: bus_sel with bus_wr high writes at the edge,
// and bus_sel with bus_wr low reads combinationally.
module gpio_port16
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out
);

    logic [NPINS-1:0] dir_q, lat_q, od_q, ana_q, smp_q;
    logic [NPINS-1:0] port_view;
    logic             wr_en;
    logic             rd_en;

    // Bus strobes.
    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr & addr_is_mapped(bus_addr);

    gpio_cfg_regs #(.W(NPINS)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .lat_q (lat_q),
        .od_q  (od_q),
        .ana_q (ana_q)
    );

    gpio_pad_drv #(.W(NPINS)) drv_i (
        .dir     (dir_q),
        .lat     (lat_q),
        .od      (od_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    gpio_in_sample #(.W(NPINS), .STAGES(SYNC_STAGES)) smp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .smp_q  (smp_q)
    );

    // Analog-selected pins read as zero.
    assign port_view = smp_q & ~ana_q;

    // Read data multiplexer; idle and unmapped reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (reg_addr_e'(bus_addr))
                RA_DIR:   bus_rdata = dir_q;
                RA_PORT:  bus_rdata = port_view;
                RA_LAT:   bus_rdata = lat_q;
                RA_ODRN:  bus_rdata = od_q;
                RA_ANSEL: bus_rdata = ana_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port16_chk.sv
// Assertion checker for the GPIO port, attached to the top by bind.
// It checks register updates, pad drive rules, the analog mask, the
// sampling latency and the idle read value.
module gpio_port16_chk
    import gpio_port_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pad_in,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      lat_q,
    input logic [W-1:0]      od_q,
    input logic [W-1:0]      ana_q,
    input logic [W-1:0]      smp_q
);

    // R2: a direction write lands at the next edge.
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 3'd0) |=> dir_q == $past(bus_wdata));

    // R2: input pins never drive.
    p_input_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q) == '0);

    // R3: push-pull outputs are enabled and carry the latch bit.
    p_pushpull_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~od_q) & (~pad_oe | (pad_out ^ lat_q))) == '0);

    // R4: an open-drain pin never drives high.
    p_od_no_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & od_q & pad_out) == '0 && (pad_oe & od_q & lat_q) == '0);

    // R5: writes to the port or latch address update the latch.
    p_latch_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd2))
        |=> lat_q == $past(bus_wdata));

    // R6: analog pins read as zero on the port address.
    p_analog_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 3'd1) |-> (bus_rdata & ana_q) == '0);

    // R9: unmapped writes leave every register unchanged.
    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr > 3'd4)
        |=> $stable({dir_q, lat_q, od_q, ana_q}));

    // R10: no read strobe, no read data.
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || bus_wr) |-> bus_rdata == '0);

    // R8: with one sampling stage the read-back lags the pads by one clock.
    if (SYNC_STAGES == 1) begin : g_one_stage
        p_sample_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> smp_q == $past(pad_in));
    end

endmodule

bind gpio_port16 gpio_port16_chk #(.W(NPINS), .SYNC_STAGES(SYNC_STAGES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .od_q      (od_q),
    .ana_q     (ana_q),
    .smp_q     (smp_q)
);

// File: tb/gpio_port16_tb_top.sv
// Self-checking bench for the GPIO port: a vector table walked by one loop,
// then directed tests for drive modes, latency, pull-down and reset.
module gpio_port16_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  NV         = 22;
    localparam int  WDOG       = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic [15:0] pad_in, pad_oe, pad_out;
    logic [15:0] ext_en, ext_val;
    int          n_vec = 0;
    int          n_bad = 0;
    logic        done = 1'b0;
    logic [15:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pad model: driven pins carry pad_out, otherwise an outside source or the pull-up.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_en & ext_val) | (~pad_oe & ~ext_en);

    gpio_port16 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    // Vector: {write, addr, data, expected read, requirement number}.
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 3'd0, 16'h0000, 16'hFFFF, 4'd1},  // R1 direction after reset
        {1'b0, 3'd4, 16'h0000, 16'hFFFF, 4'd1},  // R1 analog after reset
        {1'b0, 3'd1, 16'h0000, 16'h0000, 4'd6},  // R6 all analog reads 0
        {1'b1, 3'd4, 16'h0000, 16'h0000, 4'd6},  // all pins digital
        {1'b0, 3'd1, 16'h0000, 16'hFFFF, 4'd6},  // R6 pull-ups seen
        {1'b1, 3'd0, 16'hFF00, 16'h0000, 4'd2},  // R2 upper in, lower out
        {1'b1, 3'd2, 16'h00A5, 16'h0000, 4'd5},  // latch write
        {1'b0, 3'd2, 16'h0000, 16'h00A5, 4'd5},  // R5 latch read
        {1'b0, 3'd1, 16'h0000, 16'hFFA5, 4'd3},  // R3 push-pull read-back
        {1'b1, 3'd3, 16'h00FF, 16'h0000, 4'd4},  // low byte open-drain
        {1'b0, 3'd0, 16'h0000, 16'hFF00, 4'd2},  // R2 direction read
        {1'b0, 3'd1, 16'h0000, 16'hFFA5, 4'd11}, // R11 released reads high
        {1'b1, 3'd4, 16'h0F0F, 16'h0000, 4'd6},  // partial analog
        {1'b0, 3'd1, 16'h0000, 16'hF0A0, 4'd6},  // R6 mask applied
        {1'b1, 3'd1, 16'h005A, 16'h0000, 4'd5},  // port address write
        {1'b0, 3'd2, 16'h0000, 16'h005A, 4'd5},  // R5 port write hit latch
        {1'b0, 3'd3, 16'h0000, 16'h00FF, 4'd4},  // R4 open-drain read
        {1'b0, 3'd1, 16'h0000, 16'hF050, 4'd6},  // R6 new pads masked
        {1'b1, 3'd5, 16'hFFFF, 16'h0000, 4'd9},  // unmapped write
        {1'b0, 3'd5, 16'h0000, 16'h0000, 4'd9},  // R9 unmapped read 0
        {1'b0, 3'd0, 16'h0000, 16'hFF00, 4'd9},  // R9 direction kept
        {1'b0, 3'd2, 16'h0000, 16'h005A, 4'd9}   // R9 latch kept
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Each task starts at a negedge and ends at the next one.
    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        ext_en = '0; ext_val = '0;
        repeat (3) @(negedge clk);
        check("R1 pad_oe in reset", pad_oe, 16'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][39]) begin
                bus_write(VEC[i][38:36], VEC[i][35:20]);
            end else begin
                bus_read(VEC[i][38:36], got);
                check($sformatf("R%0d vector %0d", VEC[i][3:0], i), got, VEC[i][19:4]);
            end
        end

        // R10: idle bus returns zero.
        #1 check("R10 idle rdata", bus_rdata, 16'h0000);
        bus_wr = 1'b1; bus_sel = 1'b0;
        #1 check("R10 write-only rdata", bus_rdata, 16'h0000);
        bus_wr = 1'b0;
        @(negedge clk);

        // R4: latch 005A with low byte open-drain.
        check("R4 open-drain oe", pad_oe, 16'h00A5);
        check("R4 open-drain out", pad_out, 16'h0000);

        // R3: back to push-pull.
        bus_write(3'd3, 16'h0000);
        check("R3 push-pull oe", pad_oe, 16'h00FF);
        check("R3 push-pull out", pad_out, 16'h005A);

        // R7: all analog, outputs still driven.
        bus_write(3'd4, 16'hFFFF);
        check("R7 analog output oe", pad_oe, 16'h00FF);
        check("R7 analog output out", pad_out, 16'h005A);
        bus_read(3'd1, got);
        check("R6 all analog port", got, 16'h0000);

        // R8: direction change latency on pin 13.
        bus_write(3'd4, 16'h0000);
        bus_write(3'd2, 16'h0000);
        bus_read(3'd1, got);
        bus_read(3'd1, got);
        check("R8 settled before change", got, 16'hFF00);
        bus_write(3'd0, 16'hDF00);
        bus_read(3'd1, got);
        check("R8 first read old", got, 16'hFF00);
        bus_read(3'd1, got);
        check("R8 second read new", got, 16'hDF00);

        // R11: released open-drain lines, one pulled low from outside.
        bus_write(3'd3, 16'h00FF);
        bus_write(3'd2, 16'h00FF);
        ext_en = 16'h0020; ext_val = 16'h0000;
        bus_read(3'd1, got);
        bus_read(3'd1, got);
        check("R11 released and pulled", got, 16'hDFDF);
        check("R11 released oe", pad_oe, 16'h2000);
        ext_en = '0;

        // R1: reset in mid-run restores defaults.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pad_oe after reset", pad_oe, 16'h0000);
        rst_n = 1'b1;
        bus_read(3'd0, got);
        check("R1 direction after reset", got, 16'hFFFF);
        bus_read(3'd2, got);
        check("R1 latch after reset", got, 16'h0000);
        bus_read(3'd3, got);
        check("R1 open-drain after reset", got, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule